// File: doc/BRIEF.md
# Read-Window Termination and Bus-Drive Scheduler

This block plans, at half-cycle resolution, who owns a shared bidirectional data bus in front of a burst-of-two double-data-rate memory. It watches one command per clock cycle (no-op, read or write). From that stream it produces the memory-side pull-up and pull-down termination enables, and three controller-side enables: drive write data, drive the bus low, and switch on the controller's own termination to receive read data.

Each output is a two-bit vector that covers one clock cycle. Bit 0 is the first half-cycle after a rising edge and bit 1 is the second half-cycle. Every window therefore starts and ends on a half-cycle boundary, and no double-rate clock is needed.

Positions are counted in half-cycles after the rising edge that samples a command. Position 0 is the first half that follows that edge. Read data takes two positions, starting at L. L is 5 for the 2.5-cycle latency and 4 for the 2.0-cycle latency. Write data takes positions 2 and 3. The latency select, mode and termination pin must stay steady while a command is still inside its window. A write must follow a read by at least four cycles.

Top module: `dq_odt_sched`

## Requirements
- R1: While reset is held and afterwards with no traffic, drive-low is 2'b11, write drive and controller termination are 2'b00, and both memory enables equal the termination pin on both halves.
- R2: With `lat_short_i`=0, a read sampled at an edge places its data beats at positions 5 and 6.
- R3: With `lat_short_i`=1, the beats move to positions 4 and 5.
- R4: With `pd_beats_only_i`=0 and the pin at 1, pull-up and pull-down are both off at positions L-1 through L+2 and on elsewhere.
- R5: With `pd_beats_only_i`=1 and the pin at 1, pull-up is off at L-1 through L+2, while pull-down is off only at the beats L and L+1.
- R6: While `term_pin_i` is 0, both memory enables are 2'b00 whatever the traffic.
- R7: Controller termination is on exactly at positions L-1 through L+4 of every read, and drive-low is off there.
- R8: A write sampled at an edge asserts write drive at positions 2 and 3, and drive-low is off there.
- R9: Reads on consecutive cycles merge into one unbroken window, with no half-cycle gap in any enable.
- R10: Write drive and controller termination are never on in the same half-cycle when writes keep the spacing stated above.
- R11: Drive-low is on in every half-cycle where neither write drive nor controller termination is on.
- R12: Command codes are 2'b00 no-op, 2'b01 read, 2'b10 write. Code 2'b11 acts as a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one command per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Command code sampled each rising edge |
| lat_short_i | input | 1 | 1 selects the 2.0-cycle read latency, 0 the 2.5-cycle one |
| pd_beats_only_i | input | 1 | 1 limits pull-down release to the data beats |
| term_pin_i | input | 1 | Memory termination enable pin |
| mem_pu_en_o | output | 2 | Memory pull-up enable per half-cycle |
| mem_pd_en_o | output | 2 | Memory pull-down enable per half-cycle |
| ctl_wr_drv_o | output | 2 | Controller drives write data per half-cycle |
| ctl_drv_low_o | output | 2 | Controller drives the bus low per half-cycle |
| ctl_term_en_o | output | 2 | Controller termination enable per half-cycle |

## Verification
The hardest case to reach is overlap: several reads in flight at once, with their guard and receive tails running across half-cycle boundaries, while a write is placed right at the spacing limit. The stimulus sends runs of two and three back-to-back reads in both latencies and both modes. It then places a write exactly four cycles after a read, and a read one cycle after a write. A queue-based model rebuilds every half-cycle from the offsets of all commands still in flight.

// File: rtl/dq_odt_pkg.sv
package dq_odt_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_RSV = 2'b11
  } bus_cmd_e;

  // half-cycles per clock cycle; each output carries one bit per half
  localparam int HALVES = 2;

  // true when half-cycle position pos falls within [first, first+len)
  function automatic logic span_hit(input int pos, input int first, input int len);
    return (pos >= first) && (pos < first + len);
  endfunction

  // clock cycles of history needed to reach half-cycle position last_pos
  function automatic int hist_depth(input int last_pos);
    return last_pos / HALVES + 1;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dq_odt_hist.sv
module dq_odt_hist
  import dq_odt_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_i,
  output logic [DEPTH-1:0] rd_hist_o,
  output logic [DEPTH-1:0] wr_hist_o
);

  logic is_rd, is_wr;
  assign is_rd = (bus_cmd_e'(cmd_i) == CMD_RD);
  assign is_wr = (bus_cmd_e'(cmd_i) == CMD_WR);

  // bit k holds the command sampled k edges before the present cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hist_o <= '0;
      wr_hist_o <= '0;
    end else begin
      rd_hist_o <= {rd_hist_o[DEPTH-2:0], is_rd};
      wr_hist_o <= {wr_hist_o[DEPTH-2:0], is_wr};
    end
  end

endmodule

// File: rtl/dq_odt_window.sv
module dq_odt_window
  import dq_odt_pkg::*;
#(
  parameter int DEPTH       = 5,
  parameter int LAT_LONG_H  = 5,
  parameter int LAT_SHORT_H = 4,
  parameter int WR_LAT_H    = 2,
  parameter int GUARD_H     = 1,
  parameter int TAIL_H      = 3,
  parameter int BURST_H     = 2
) (
  input  logic [DEPTH-1:0]  rd_hist_i,
  input  logic [DEPTH-1:0]  wr_hist_i,
  input  logic              lat_short_i,
  output logic [HALVES-1:0] beat_o,
  output logic [HALVES-1:0] guard_o,
  output logic [HALVES-1:0] rx_o,
  output logic [HALVES-1:0] wbeat_o
);

  localparam int GUARD_LEN = BURST_H + 2 * GUARD_H;
  localparam int RX_LEN    = BURST_H + GUARD_H + TAIL_H;

  for (genvar j = 0; j < HALVES; j++) begin : g_half
    logic b, g, r, w;
    always_comb begin
      int lat;
      lat = lat_short_i ? LAT_SHORT_H : LAT_LONG_H;
      b = 1'b0;
      g = 1'b0;
      r = 1'b0;
      w = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
        if (rd_hist_i[k]) begin
          b = b | span_hit(HALVES * k + j, lat, BURST_H);
          g = g | span_hit(HALVES * k + j, lat - GUARD_H, GUARD_LEN);
          r = r | span_hit(HALVES * k + j, lat - GUARD_H, RX_LEN);
        end
        if (wr_hist_i[k]) begin
          w = w | span_hit(HALVES * k + j, WR_LAT_H, BURST_H);
        end
      end
    end
    assign beat_o[j]  = b;
    assign guard_o[j] = g;
    assign rx_o[j]    = r;
    assign wbeat_o[j] = w;
  end

endmodule

// File: rtl/dq_odt_drive.sv
module dq_odt_drive
  import dq_odt_pkg::*;
(
  input  logic [HALVES-1:0] beat_i,
  input  logic [HALVES-1:0] guard_i,
  input  logic [HALVES-1:0] rx_i,
  input  logic [HALVES-1:0] wbeat_i,
  input  logic              term_pin_i,
  input  logic              pd_beats_only_i,
  output logic [HALVES-1:0] mem_pu_en_o,
  output logic [HALVES-1:0] mem_pd_en_o,
  output logic [HALVES-1:0] ctl_wr_drv_o,
  output logic [HALVES-1:0] ctl_drv_low_o,
  output logic [HALVES-1:0] ctl_term_en_o
);

  logic [HALVES-1:0] pin_mask, pd_release;

  assign pin_mask      = {HALVES{term_pin_i}};
  assign pd_release    = pd_beats_only_i ? beat_i : guard_i;
  assign mem_pu_en_o   = pin_mask & ~guard_i;
  assign mem_pd_en_o   = pin_mask & ~pd_release;
  assign ctl_term_en_o = rx_i;
  assign ctl_wr_drv_o  = wbeat_i;
  assign ctl_drv_low_o = ~(rx_i | wbeat_i);

endmodule

// File: rtl/dq_odt_sched.sv
module dq_odt_sched
  import dq_odt_pkg::*;
#(
  parameter int LAT_LONG_H  = 5,  // 2.5-cycle read latency in half-cycles
  parameter int LAT_SHORT_H = 4,  // 2.0-cycle read latency in half-cycles
  parameter int WR_LAT_H    = 2,  // write data offset in half-cycles
  parameter int GUARD_H     = 1,  // memory guard around read beats
  parameter int TAIL_H      = 3,  // controller receive tail after beats
  parameter int BURST_H     = 2   // two beats at double data rate
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmd_i,
  input  logic       lat_short_i,
  input  logic       pd_beats_only_i,
  input  logic       term_pin_i,
  output logic [1:0] mem_pu_en_o,
  output logic [1:0] mem_pd_en_o,
  output logic [1:0] ctl_wr_drv_o,
  output logic [1:0] ctl_drv_low_o,
  output logic [1:0] ctl_term_en_o
);

  localparam int LAST_RD_POS = max2(LAT_LONG_H, LAT_SHORT_H) + BURST_H - 1 + TAIL_H;
  localparam int LAST_WR_POS = WR_LAT_H + BURST_H - 1;
  localparam int DEPTH       = max2(2, hist_depth(max2(LAST_RD_POS, LAST_WR_POS)));

  logic [DEPTH-1:0]  rd_hist, wr_hist;
  // named internal events, observed by the bound checker
  logic [HALVES-1:0] rd_beat, rd_guard, rx_win, wr_beat;

  dq_odt_hist #(.DEPTH(DEPTH)) hist_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (cmd_i),
    .rd_hist_o (rd_hist),
    .wr_hist_o (wr_hist)
  );

  dq_odt_window #(
    .DEPTH       (DEPTH),
    .LAT_LONG_H  (LAT_LONG_H),
    .LAT_SHORT_H (LAT_SHORT_H),
    .WR_LAT_H    (WR_LAT_H),
    .GUARD_H     (GUARD_H),
    .TAIL_H      (TAIL_H),
    .BURST_H     (BURST_H)
  ) window_i (
    .rd_hist_i   (rd_hist),
    .wr_hist_i   (wr_hist),
    .lat_short_i (lat_short_i),
    .beat_o      (rd_beat),
    .guard_o     (rd_guard),
    .rx_o        (rx_win),
    .wbeat_o     (wr_beat)
  );

  dq_odt_drive drive_i (
    .beat_i          (rd_beat),
    .guard_i         (rd_guard),
    .rx_i            (rx_win),
    .wbeat_i         (wr_beat),
    .term_pin_i      (term_pin_i),
    .pd_beats_only_i (pd_beats_only_i),
    .mem_pu_en_o     (mem_pu_en_o),
    .mem_pd_en_o     (mem_pd_en_o),
    .ctl_wr_drv_o    (ctl_wr_drv_o),
    .ctl_drv_low_o   (ctl_drv_low_o),
    .ctl_term_en_o   (ctl_term_en_o)
  );

endmodule

// File: rtl/dq_odt_sched_chk.sv
module dq_odt_sched_chk
  import dq_odt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd_i,
  input logic       lat_short_i,
  input logic       pd_beats_only_i,
  input logic       term_pin_i,
  input logic [1:0] mem_pu_en_o,
  input logic [1:0] mem_pd_en_o,
  input logic [1:0] ctl_wr_drv_o,
  input logic [1:0] ctl_term_en_o,
  input logic [1:0] rd_beat
);

  p_pin_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !term_pin_i |-> (mem_pu_en_o == 2'b00 && mem_pd_en_o == 2'b00));

  p_sym_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (term_pin_i && !pd_beats_only_i) |-> (mem_pu_en_o == mem_pd_en_o));

  // a released pull-down always sits inside a released pull-up
  p_pd_in_pu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    term_pin_i |-> ((mem_pu_en_o & ~mem_pd_en_o) == 2'b00));

  p_beat_in_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_beat & ~ctl_term_en_o) == 2'b00);

  p_no_wr_term_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_drv_o & ctl_term_en_o) == 2'b00);

  // fixed delays below match the default latency parameters
  p_long_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_i == CMD_RD, 3) && !lat_short_i) |-> (ctl_term_en_o == 2'b11));

  p_short_beats_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_i == CMD_RD, 3) && lat_short_i && term_pin_i) |-> (mem_pd_en_o == 2'b00));

  p_write_beats_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_i == CMD_WR, 2) |-> (ctl_wr_drv_o == 2'b11));

endmodule

bind dq_odt_sched dq_odt_sched_chk chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_i           (cmd_i),
  .lat_short_i     (lat_short_i),
  .pd_beats_only_i (pd_beats_only_i),
  .term_pin_i      (term_pin_i),
  .mem_pu_en_o     (mem_pu_en_o),
  .mem_pd_en_o     (mem_pd_en_o),
  .ctl_wr_drv_o    (ctl_wr_drv_o),
  .ctl_term_en_o   (ctl_term_en_o),
  .rd_beat         (rd_beat)
);

// File: tb/dq_odt_sched_tb_top.sv
module dq_odt_sched_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cmd;
  logic       lat_short, pd_only, term_pin;
  logic [1:0] pu, pd, wr_drv, drv_low, term_en;

  always #5 clk = ~clk;

  dq_odt_sched dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_i           (cmd),
    .lat_short_i     (lat_short),
    .pd_beats_only_i (pd_only),
    .term_pin_i      (term_pin),
    .mem_pu_en_o     (pu),
    .mem_pd_en_o     (pd),
    .ctl_wr_drv_o    (wr_drv),
    .ctl_drv_low_o   (drv_low),
    .ctl_term_en_o   (term_en)
  );

  typedef struct {int edge_n; bit rd;} ev_t;
  ev_t   sb_q[$];
  int    ecount = 0;
  int    n_cmp = 0, n_bad = 0;
  string phase = "R1";
  bit    mon_on = 1'b0;

  always @(posedge clk) ecount <= ecount + 1;

  task automatic chk(input string req, input string what,
                     input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (phase %s, edge %0d)",
               req, what, act, exp, phase, ecount);
    end
  endtask

  // driver: one command per cycle; bus commands are queued with their edge
  task automatic issue(input logic [1:0] c);
    @(negedge clk);
    cmd = c;
    if (c == 2'b01 || c == 2'b10)
      sb_q.push_back('{edge_n: ecount + 1, rd: (c == 2'b01)});
  endtask

  task automatic idle(input int n);
    repeat (n) issue(2'b00);
  endtask

  task automatic cfg(input logic ls, input logic md, input logic tp);
    @(negedge clk);
    lat_short = ls;
    pd_only   = md;
    term_pin  = tp;
  endtask

  // monitor: rebuilds both halves of the current cycle from queued commands
  always begin
    @(posedge clk);
    #3;
    if (mon_on) begin
      logic [1:0] e_beat, e_guard, e_rx, e_w, e_pu, e_pd;
      int    lat;
      string req_mem;
      e_beat = 2'b00; e_guard = 2'b00; e_rx = 2'b00; e_w = 2'b00;
      lat = lat_short ? 4 : 5;
      while (sb_q.size() > 0 && ecount - sb_q[0].edge_n > 6) void'(sb_q.pop_front());
      foreach (sb_q[i]) begin
        for (int j = 0; j < 2; j++) begin
          int p;
          int d;
          p = 2 * (ecount - sb_q[i].edge_n) + j;
          d = p - lat;
          if (sb_q[i].edge_n <= ecount) begin
            if (sb_q[i].rd) begin
              if (d == 0 || d == 1)   e_beat[j]  = 1'b1;
              if (d >= -1 && d <= 2)  e_guard[j] = 1'b1;
              if (d >= -1 && d <= 4)  e_rx[j]    = 1'b1;
            end else if (p == 2 || p == 3) begin
              e_w[j] = 1'b1;
            end
          end
        end
      end
      e_pu = term_pin ? ~e_guard : 2'b00;
      e_pd = term_pin ? (pd_only ? ~e_beat : ~e_guard) : 2'b00;
      req_mem = !term_pin ? "R6" : (pd_only ? "R5" : "R4");
      chk(req_mem, "pull-up", pu, e_pu);
      chk(req_mem, "pull-down", pd, e_pd);
      chk("R7", "controller termination", term_en, e_rx);
      chk("R8", "write drive", wr_drv, e_w);
      chk("R11", "drive low", drv_low, ~(e_rx | e_w));
      chk("R10", "write/termination overlap", wr_drv & term_en, 2'b00);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cmd = 2'b00; lat_short = 1'b0; pd_only = 1'b0; term_pin = 1'b1; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    // R1: quiet bus during reset
    chk("R1", "reset drive low", drv_low, 2'b11);
    chk("R1", "reset termination", term_en, 2'b00);
    chk("R1", "reset write drive", wr_drv, 2'b00);
    chk("R1", "reset pull-up", pu, 2'b11);
    chk("R1", "reset pull-down", pd, 2'b11);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(3);

    phase = "R2"; issue(2'b01); idle(8);
    phase = "R4"; issue(2'b01); idle(8);
    cfg(1'b0, 1'b1, 1'b1);
    phase = "R5"; issue(2'b01); idle(8);
    cfg(1'b1, 1'b0, 1'b1);
    phase = "R3"; issue(2'b01); idle(8);
    cfg(1'b1, 1'b1, 1'b1);
    issue(2'b01); idle(8);
    cfg(1'b0, 1'b1, 1'b0);
    phase = "R6"; issue(2'b01); issue(2'b01); idle(8);
    cfg(1'b0, 1'b0, 1'b1);
    phase = "R8"; issue(2'b10); idle(2); issue(2'b10); issue(2'b01); idle(8);
    phase = "R9"; issue(2'b01); issue(2'b01); issue(2'b01); idle(8);
    cfg(1'b0, 1'b1, 1'b1);
    issue(2'b01); issue(2'b01); idle(8);
    cfg(1'b1, 1'b1, 1'b1);
    issue(2'b01); issue(2'b01); issue(2'b01); idle(8);
    cfg(1'b0, 1'b0, 1'b1);
    phase = "R10"; issue(2'b01); idle(3); issue(2'b10); idle(8);
    cfg(1'b1, 1'b1, 1'b1);
    issue(2'b01); idle(3); issue(2'b10); idle(8);
    // R12: reserved code must leave every output idle
    phase = "R12"; issue(2'b11); issue(2'b11); idle(8);
    cfg(1'b0, 1'b1, 1'b1);
    phase = "R11"; issue(2'b10); idle(1); issue(2'b01); issue(2'b01); idle(3);
    issue(2'b10); idle(8);

    mon_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule